// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

This block adds two unsigned words of `WIDTH` bits by working through them one bit position per clock, starting at the least significant bit. A load strobe captures both operand words into shift registers and starts an addition. Each later cycle shifts one bit of each operand out of the low end into a small carry-tracking state machine, and the sum bit it yields enters the high end of a result shift register. When the last bit has gone in, the result word holds the sum modulo 2^`WIDTH` with its LSB at bit 0, and the done flag rises.

The parameter `MOORE` picks the carry machine. With `MOORE = 0` a two-state machine holds only the carry, and the sum bit is formed from the current operand bits and that carry in the same cycle. With `MOORE = 1` a four-state machine holds both the carry and the sum bit, so each sum bit leaves the state register one clock after its operand bits and the addition needs one extra cycle. A fresh load always returns the carry machine to its zero-carry state and restarts the sequence, even if an addition is still running.

Top module: `serial_adder`

## Requirements
- R1: After synchronous reset, `sum` is all zeros and `done` is 0.
- R2: `done` rises exactly `WIDTH` clock edges after the edge that takes `load` (`MOORE = 0`), or `WIDTH + 1` edges after it (`MOORE = 1`), and is 0 at every edge in between.
- R3: Once `done` is 1, `sum` equals (`op_a` + `op_b`) mod 2^`WIDTH` for the operands captured at the last load.
- R4: The edge that takes `load` clears `sum` to zero and `done` to 0 and starts a new addition, which discards any addition still in progress.
- R5: A load returns the carry to zero, so a carry left from an earlier addition never changes the result of the next one.
- R6: While `done` is 1 and `load` is 0, `done` stays 1 and `sum` keeps its value.
- R7: With `MOORE = 0`, after the k-th shifting edge of an addition (k = 1..`WIDTH`), `sum[WIDTH-1]` equals bit k-1 of the true sum.
- R8: With `MOORE = 1`, after the k-th shifting edge of an addition (k = 2..`WIDTH+1`), `sum[WIDTH-1]` equals bit k-2 of the true sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture operands and start an addition |
| op_a | input | WIDTH | First operand word |
| op_b | input | WIDTH | Second operand word |
| sum | output | WIDTH | Result shift register contents |
| done | output | 1 | Addition finished; `sum` is valid |

## Verification
The assertions watch, on every cycle, that the step counter never exceeds its start value and counts down by one per shifting cycle, that a load clears the result, the flag and the carry and reloads the counter, and that a raised done flag holds together with a steady result. Whether the bits that arrive are the right ones can only be shown by the bench, which sweeps every operand pair of a four-bit configuration for both carry machines, follows the top result bit edge by edge against the arithmetic sum, and times the done flag. Carry clearing across back-to-back additions and an addition cut short by a new load are also exercised as scenarios.

// File: rtl/sa_pkg.sv
package sa_pkg;

  // Moore carry machine: bit 1 is the carry, bit 0 the presented sum bit.
  typedef enum logic [1:0] {
    ST_C0_S0 = 2'b00,
    ST_C0_S1 = 2'b01,
    ST_C1_S0 = 2'b10,
    ST_C1_S1 = 2'b11
  } moore_st_t;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic par3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

endpackage

// File: rtl/sa_shreg.sv
// Parallel-load shift register; load wins over shift; shift moves toward bit 0.
module sa_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         en,
  input  logic [W-1:0] din,
  input  logic         ser_in,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (ld) begin
      q_r <= din;
    end else if (en) begin
      q_r <= {ser_in, q_r[W-1:1]};
    end
  end

  assign q = q_r;

endmodule

// File: rtl/sa_carry_fsm.sv
// Carry tracker: MOORE=0 two-state with combinational sum bit,
// MOORE=1 four-state with registered sum bit.
module sa_carry_fsm
  import sa_pkg::*;
#(
  parameter bit MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic s_out,
  output logic carry
);

  generate
    if (MOORE) begin : g_moore
      moore_st_t  st_q;
      logic [1:0] st_bits;
      logic       c_now;

      assign st_bits = st_q;
      assign c_now   = st_bits[1];

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          st_q <= ST_C0_S0;
        end else if (en) begin
          st_q <= moore_st_t'({maj3(a, b, c_now), par3(a, b, c_now)});
        end
      end

      assign s_out = st_bits[0];
      assign carry = c_now;
    end else begin : g_mealy
      logic c_q;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          c_q <= 1'b0;
        end else if (en) begin
          c_q <= maj3(a, b, c_q);
        end
      end

      assign s_out = par3(a, b, c_q);
      assign carry = c_q;
    end
  endgenerate

endmodule

// File: rtl/sa_seq.sv
// Step counter and done flag.
module sa_seq #(
  parameter int STEPS = 8,
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          active,
  output logic          done,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= CW'(STEPS);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        done_q <= 1'b1;
      end
    end
  end

  assign active = (cnt_q != '0) && !start;
  assign done   = done_q;
  assign cnt    = cnt_q;

endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum,
  output logic             done
);

  localparam int STEPS = MOORE ? WIDTH + 1 : WIDTH;
  localparam int CW    = $clog2(STEPS + 1);

  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  logic [CW-1:0]    cnt_q;
  logic             step;
  logic             sbit;
  logic             carry_w;

  sa_seq #(.STEPS(STEPS)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (load),
    .active (step),
    .done   (done),
    .cnt    (cnt_q)
  );

  sa_shreg #(.W(WIDTH)) u_reg_a (
    .clk    (clk),
    .rst    (rst),
    .ld     (load),
    .en     (step),
    .din    (op_a),
    .ser_in (1'b0),
    .q      (a_q)
  );

  sa_shreg #(.W(WIDTH)) u_reg_b (
    .clk    (clk),
    .rst    (rst),
    .ld     (load),
    .en     (step),
    .din    (op_b),
    .ser_in (1'b0),
    .q      (b_q)
  );

  sa_carry_fsm #(.MOORE(MOORE)) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .clr   (load),
    .en    (step),
    .a     (a_q[0]),
    .b     (b_q[0]),
    .s_out (sbit),
    .carry (carry_w)
  );

  sa_shreg #(.W(WIDTH)) u_reg_s (
    .clk    (clk),
    .rst    (rst),
    .ld     (load),
    .en     (step),
    .din    ('0),
    .ser_in (sbit),
    .q      (sum)
  );

endmodule

// File: rtl/sa_chk.sv
module sa_chk #(
  parameter int WIDTH = 8,
  parameter int STEPS = 8,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             done,
  input logic [WIDTH-1:0] sum,
  input logic [CW-1:0]    cnt,
  input logic             carry
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(STEPS)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !load) |=> cnt == $past(cnt) - CW'(1)); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> cnt == '0); // R2

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    load |=> (!done && sum == '0 && cnt == CW'(STEPS))); // R4

  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    load |=> !carry); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> (done && $stable(sum))); // R6

endmodule

bind serial_adder sa_chk #(
  .WIDTH (WIDTH),
  .STEPS (STEPS),
  .CW    (CW)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .load  (load),
  .done  (done),
  .sum   (sum),
  .cnt   (cnt_q),
  .carry (carry_w)
);

// File: tb/serial_adder_bench.sv
module serial_adder_bench;

  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] sum_e, sum_o;
  logic         done_e, done_o;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  serial_adder #(.WIDTH(W), .MOORE(1'b0)) u_serial_adder (
    .clk (clk), .rst (rst), .load (load),
    .op_a (op_a), .op_b (op_b), .sum (sum_e), .done (done_e)
  );

  serial_adder #(.WIDTH(W), .MOORE(1'b1)) u_serial_adder_moore (
    .clk (clk), .rst (rst), .load (load),
    .op_a (op_a), .op_b (op_b), .sum (sum_o), .done (done_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // One full addition on both instances, with per-edge trace checks.
  task automatic run_add(input int a, input int b, input string ctx);
    int s;
    s = (a + b) & MASK;
    @(negedge clk);
    load = 1'b1;
    op_a = W'(a);
    op_b = W'(b);
    @(negedge clk);
    load = 1'b0;
    check({"R4 mealy clear ", ctx}, int'(sum_e), 0);
    check({"R4 moore clear ", ctx}, int'(sum_o), 0);
    check({"R4 mealy done low ", ctx}, int'(done_e), 0);
    check({"R4 moore done low ", ctx}, int'(done_o), 0);
    for (int k = 1; k <= W + 1; k++) begin
      @(negedge clk);
      if (k <= W)
        check({"R7 mealy msb ", ctx}, int'(sum_e[W-1]), (s >> (k - 1)) & 1);
      if (k >= 2)
        check({"R8 moore msb ", ctx}, int'(sum_o[W-1]), (s >> (k - 2)) & 1);
      check({"R2 mealy done ", ctx}, int'(done_e), (k >= W) ? 1 : 0);
      check({"R2 moore done ", ctx}, int'(done_o), (k >= W + 1) ? 1 : 0);
    end
    check({"R3 mealy sum ", ctx}, int'(sum_e), s);
    check({"R3 moore sum ", ctx}, int'(sum_o), s);
  endtask

  initial begin
    #200000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mealy sum", int'(sum_e), 0);
    check("R1 moore sum", int'(sum_o), 0);
    check("R1 mealy done", int'(done_e), 0);
    check("R1 moore done", int'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mealy done idle", int'(done_e), 0);
    check("R1 moore done idle", int'(done_o), 0);

    // Exhaustive sweep of operand pairs
    for (int a = 0; a <= MASK; a++) begin
      for (int b = 0; b <= MASK; b++) begin
        run_add(a, b, "sweep");
      end
    end

    // R6: result and flag hold while idle
    run_add(9, 5, "hold");
    repeat (4) begin
      @(negedge clk);
      check("R6 mealy done hold", int'(done_e), 1);
      check("R6 moore done hold", int'(done_o), 1);
      check("R6 mealy sum hold", int'(sum_e), 14);
      check("R6 moore sum hold", int'(sum_o), 14);
    end

    // R5: carry out of a previous addition must not leak
    run_add(MASK, MASK, "R5 carry source");
    run_add(0, 0, "R5 after carry");
    run_add(MASK, 1, "R5 wrap");
    run_add(1, 0, "R5 after wrap");

    // R4: a load in the middle of an addition restarts it
    @(negedge clk);
    load = 1'b1;
    op_a = W'(MASK);
    op_b = W'(MASK);
    @(negedge clk);
    load = 1'b0;
    repeat (2) @(negedge clk);
    run_add(3, 6, "R4 abort");

    finish_run();
  end

endmodule